// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This block returns the larger or the smaller of two IEEE-754 binary floating-point operands. It works on raw bit patterns in either single precision (32-bit) or double precision (64-bit), chosen per request by a precision input. Four operations are available: plain maximum, plain minimum, and "number" forms of each. The number forms prefer a numeric operand over a lone quiet NaN.

NaN handling follows strict architectural rules. A NaN result is chosen by a fixed priority. A signaling NaN is returned in quieted form with its sign and payload kept. The unit raises an invalid-operation flag whenever a signaling NaN is seen. Signed zeros are ordered so that -0 ranks below +0.

Each request is presented with a valid strobe. The result, the flag and an output strobe appear registered one clock later. Outputs hold their value between requests.

Top module: `fp_minmax_unit`

## Requirements
- R1: An operand is a quiet NaN when its exponent field is all ones and its fraction MSB is 1. It is a signaling NaN when its exponent field is all ones, its fraction MSB is 0 and its fraction is nonzero. An all-ones exponent with a zero fraction is an infinity and is ordered as a number.
- R2: When a NaN result is produced, it is chosen in this priority order: signaling NaN in operand A, signaling NaN in operand B, quiet NaN in operand A, quiet NaN in operand B.
- R3: A chosen signaling NaN is output with its fraction MSB set (bit 22 for single, bit 51 for double), with its sign and other payload bits unchanged. A chosen quiet NaN is output unchanged.
- R4: For non-NaN operands, op_sel 0 (max) returns the numerically larger operand and op_sel 1 (min) returns the smaller one. Infinities are included.
- R5: Under max, two zero operands give -0 only when both are -0, and +0 otherwise.
- R6: Under min, two zero operands give -0 when either is -0, and +0 otherwise.
- R7: op_sel 2 (max-number) and op_sel 3 (min-number) work as follows when exactly one operand is a quiet NaN: that operand is replaced by -infinity (max-number) or +infinity (min-number) before the max or min is taken. In every other case these ops follow R2 and R3.
- R8: When the two operands are equal, nonzero and not NaN, the result is operand B.
- R9: prec_dbl=1 selects double precision on all 64 bits. prec_dbl=0 selects single precision on bits [31:0]: bits [63:32] of both operands are ignored and result[63:32] is zero.
- R10: invalid_flag is 1 for a request in which either operand, in the selected precision, is a signaling NaN, and 0 otherwise.
- R11: result, invalid_flag and out_valid update on the clock edge that samples in_valid=1, so they appear one cycle after the request. out_valid follows in_valid with a one-cycle delay. result and invalid_flag hold while in_valid=0. Reset clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 0 max, 1 min, 2 max-number, 3 min-number |
| prec_dbl | input | 1 | 1 double precision, 0 single precision |
| opnd_a | input | 64 | Operand A bit pattern |
| opnd_b | input | 64 | Operand B bit pattern |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 64 | Result bit pattern |
| invalid_flag | output | 1 | Signaling NaN seen in the request |

## Verification
Every result, the invalid flag and out_valid of a request are due exactly one clock after the edge that samples its in_valid. The bench drives each request on a falling edge and samples the outputs on the next falling edge, which is half a period after the edge that registers them. Requests run back to back, so each sample also shows that the previous request does not linger. For the hold case, a cycle with in_valid low and changed operands is sampled at the same point to confirm that the outputs did not move.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int DATA_W     = 1 + DBL_EXP_W + DBL_FRAC_W;
  localparam int NUM_FMT    = 2;

  typedef enum logic [1:0] {
    OP_MAX    = 2'd0,
    OP_MIN    = 2'd1,
    OP_MAXNUM = 2'd2,
    OP_MINNUM = 2'd3
  } mm_op_e;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output logic                  is_qnan,
  output logic                  is_snan
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic exp_full;
  logic frac_any;
  logic quiet_bit;

  assign exp_full  = &val[W-2:FRAC_W];
  assign frac_any  = |val[FRAC_W-1:0];
  assign quiet_bit = val[FRAC_W-1];

  // R1: quiet bit set implies a nonzero fraction
  assign is_qnan = exp_full & quiet_bit & frac_any;
  assign is_snan = exp_full & ~quiet_bit & frac_any;
endmodule

// File: rtl/fpmm_core.sv
module fpmm_core
  import fpmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] opa,
  input  logic [EXP_W+FRAC_W:0] opb,
  input  logic [1:0]            op,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  snan_seen
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QUIET_MASK = W'(1) << (FRAC_W - 1);

  // Sign-magnitude to monotonic unsigned key
  function automatic logic [W-1:0] order_key(input logic [W-1:0] v);
    order_key = v[W-1] ? ~v : {1'b1, v[W-2:0]};
  endfunction

  function automatic logic [W-1:0] make_inf(input logic neg);
    make_inf = {neg, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  mm_op_e   op_e;
  logic     want_max;
  logic     num_mode;
  logic     qa, sa, qb, sb;
  logic     swap_a, swap_b;
  logic     qa_eff, qb_eff;
  logic [W-1:0] a_eff, b_eff;
  logic [W-1:0] key_a, key_b;
  logic     pick_a;
  logic     nan_hit;
  logic [W-1:0] nan_res;

  assign op_e     = mm_op_e'(op);
  assign want_max = (op_e == OP_MAX) || (op_e == OP_MAXNUM);
  assign num_mode = (op_e == OP_MAXNUM) || (op_e == OP_MINNUM);

  fpmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .val(opa), .is_qnan(qa), .is_snan(sa)
  );
  fpmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .val(opb), .is_qnan(qb), .is_snan(sb)
  );

  // R7: lone quiet NaN stands in as the neutral infinity
  assign swap_a = num_mode & qa & ~qb;
  assign swap_b = num_mode & qb & ~qa;
  assign a_eff  = swap_a ? make_inf(want_max) : opa;
  assign b_eff  = swap_b ? make_inf(want_max) : opb;
  assign qa_eff = qa & ~swap_a;
  assign qb_eff = qb & ~swap_b;

  // R2/R3: prioritised NaN selection with quieting
  always_comb begin
    nan_hit = 1'b1;
    nan_res = '0;
    if (sa)          nan_res = opa | QUIET_MASK;
    else if (sb)     nan_res = opb | QUIET_MASK;
    else if (qa_eff) nan_res = a_eff;
    else if (qb_eff) nan_res = b_eff;
    else             nan_hit = 1'b0;
  end

  // R4/R5/R6/R8: key order puts -0 below +0; ties give operand B
  assign key_a  = order_key(a_eff);
  assign key_b  = order_key(b_eff);
  assign pick_a = want_max ? (key_a > key_b) : (key_a < key_b);

  assign res       = nan_hit ? nan_res : (pick_a ? a_eff : b_eff);
  assign snan_seen = sa | sb;
endmodule

// File: rtl/fpmm_outreg.sv
module fpmm_outreg #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] d_res,
  input  logic          d_inv,
  output logic [DW-1:0] q_res,
  output logic          q_inv,
  output logic          q_vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_res <= '0;
      q_inv <= 1'b0;
      q_vld <= 1'b0;
    end else begin
      q_vld <= cap;
      if (cap) begin
        q_res <= d_res;
        q_inv <= d_inv;
      end
    end
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fpmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic              prec_dbl,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              invalid_flag
);
  logic [DATA_W-1:0] fmt_res  [NUM_FMT];
  logic              fmt_snan [NUM_FMT];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FMT; gi++) begin : g_fmt
      localparam int EW = (gi == 0) ? SGL_EXP_W  : DBL_EXP_W;
      localparam int FW = (gi == 0) ? SGL_FRAC_W : DBL_FRAC_W;
      localparam int FMT_W = 1 + EW + FW;
      logic [FMT_W-1:0] r;
      fpmm_core #(.EXP_W(EW), .FRAC_W(FW)) u_core (
        .opa      (opnd_a[FMT_W-1:0]),
        .opb      (opnd_b[FMT_W-1:0]),
        .op       (op_sel),
        .res      (r),
        .snan_seen(fmt_snan[gi])
      );
      // R9: narrow format zero-extends into the upper bits
      assign fmt_res[gi] = DATA_W'(r);
    end
  endgenerate

  logic [DATA_W-1:0] sel_res;
  logic              sel_snan;

  assign sel_res  = prec_dbl ? fmt_res[1]  : fmt_res[0];
  assign sel_snan = prec_dbl ? fmt_snan[1] : fmt_snan[0];

  fpmm_outreg #(.DW(DATA_W)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .cap  (in_valid),
    .d_res(sel_res),
    .d_inv(sel_snan),
    .q_res(result),
    .q_inv(invalid_flag),
    .q_vld(out_valid)
  );
endmodule

// File: rtl/fp_minmax_unit_chk.sv
module fp_minmax_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        prec_dbl,
  input logic        sel_snan,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        invalid_flag
);
  p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(invalid_flag)));
  p_invalid_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_snan) |=> invalid_flag);
  p_invalid_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sel_snan) |=> !invalid_flag);
  p_quiet_sgl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !prec_dbl && sel_snan) |=> (result[30:22] == 9'h1FF));
  p_quiet_dbl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec_dbl && sel_snan) |=> (result[62:51] == 12'hFFF));
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !prec_dbl) |=> (result[63:32] == 32'h0));
endmodule

bind fp_minmax_unit fp_minmax_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .prec_dbl    (prec_dbl),
  .sel_snan    (sel_snan),
  .out_valid   (out_valid),
  .result      (result),
  .invalid_flag(invalid_flag)
);

// File: tb/test_fp_minmax_unit.sv
module test_fp_minmax_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic        prec_dbl = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid_flag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  fp_minmax_unit i_fp_minmax_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .prec_dbl(prec_dbl), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .invalid_flag(invalid_flag)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  op;
    logic        dbl;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp_res;
    logic        exp_inv;
  } vec_t;

  localparam int NV = 29;
  // op: 0 max, 1 min, 2 max-number, 3 min-number
  localparam vec_t VEC [NV] = '{
    '{4'd2,  2'd0, 1'b0, 64'h7F800001, 64'h7FC00042, 64'h7FC00001, 1'b1}, // R2 sNaN A first
    '{4'd2,  2'd0, 1'b0, 64'h7FC00042, 64'h7F800001, 64'h7FC00001, 1'b1}, // R2 sNaN B over qNaN A
    '{4'd2,  2'd0, 1'b0, 64'h7FC0000A, 64'h7FC0000B, 64'h7FC0000A, 1'b0}, // R2 qNaN A first
    '{4'd2,  2'd1, 1'b0, 64'h7FC0000A, 64'h7FC0000B, 64'h7FC0000A, 1'b0}, // R2 min too
    '{4'd4,  2'd0, 1'b0, 64'h7F7FFFFF, 64'h807FFFFF, 64'h7F7FFFFF, 1'b0}, // R4
    '{4'd4,  2'd1, 1'b0, 64'h7F7FFFFF, 64'h807FFFFF, 64'h807FFFFF, 1'b0}, // R4
    '{4'd1,  2'd0, 1'b0, 64'h3F800000, 64'h7FC00000, 64'h7FC00000, 1'b0}, // R1 qNaN propagates
    '{4'd7,  2'd2, 1'b0, 64'h3F800000, 64'h7FC00000, 64'h3F800000, 1'b0}, // R7
    '{4'd7,  2'd3, 1'b0, 64'h7FC00000, 64'hBF800000, 64'hBF800000, 1'b0}, // R7
    '{4'd7,  2'd2, 1'b0, 64'hFFC00005, 64'hFF800000, 64'hFF800000, 1'b0}, // R7 vs -inf
    '{4'd7,  2'd3, 1'b0, 64'h7FC00001, 64'h7FC00002, 64'h7FC00001, 1'b0}, // R7 both qNaN
    '{4'd7,  2'd2, 1'b0, 64'h7FC00003, 64'h7F800007, 64'h7FC00007, 1'b1}, // R7 sNaN wins
    '{4'd3,  2'd1, 1'b0, 64'hFF812345, 64'h3F800000, 64'hFFC12345, 1'b1}, // R3 sign+payload
    '{4'd5,  2'd0, 1'b1, 64'h0, 64'h8000000000000000, 64'h0, 1'b0},       // R5
    '{4'd5,  2'd0, 1'b1, 64'h8000000000000000, 64'h0, 64'h0, 1'b0},       // R5
    '{4'd5,  2'd0, 1'b1, 64'h8000000000000000, 64'h8000000000000000, 64'h8000000000000000, 1'b0}, // R5
    '{4'd6,  2'd1, 1'b1, 64'h0, 64'h8000000000000000, 64'h8000000000000000, 1'b0}, // R6
    '{4'd6,  2'd1, 1'b1, 64'h0, 64'h0, 64'h0, 1'b0},                      // R6
    '{4'd6,  2'd1, 1'b0, 64'h80000000, 64'h00000000, 64'h80000000, 1'b0}, // R6 single
    '{4'd4,  2'd0, 1'b1, 64'h3FF0000000000000, 64'hC000000000000000, 64'h3FF0000000000000, 1'b0}, // R4
    '{4'd4,  2'd1, 1'b1, 64'h3FF0000000000000, 64'hC000000000000000, 64'hC000000000000000, 1'b0}, // R4
    '{4'd3,  2'd0, 1'b1, 64'h7FF0000000000001, 64'h3FF0000000000000, 64'h7FF8000000000001, 1'b1}, // R3
    '{4'd3,  2'd1, 1'b1, 64'h7FF8000000000000, 64'hFFF0000000000002, 64'hFFF8000000000002, 1'b1}, // R3
    '{4'd9,  2'd0, 1'b0, 64'hDEADBEEF3F800000, 64'h1234567840000000, 64'h40000000, 1'b0}, // R9
    '{4'd4,  2'd0, 1'b1, 64'hC000000000000000, 64'hBFF0000000000000, 64'hBFF0000000000000, 1'b0}, // R4
    '{4'd8,  2'd0, 1'b0, 64'h41200000, 64'h41200000, 64'h41200000, 1'b0}, // R8
    '{4'd4,  2'd0, 1'b0, 64'h7F800000, 64'h7F7FFFFF, 64'h7F800000, 1'b0}, // R4 inf
    '{4'd4,  2'd1, 1'b0, 64'hFF800000, 64'h80000001, 64'hFF800000, 1'b0}, // R4 -inf
    '{4'd10, 2'd0, 1'b0, 64'h7FF0000000000001, 64'h2, 64'h2, 1'b0}       // R10 upper ignored
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11 reset result", result, 64'd0);
    chk("R11 reset invalid", {63'd0, invalid_flag}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      op_sel   = VEC[i].op;
      prec_dbl = VEC[i].dbl;
      opnd_a   = VEC[i].a;
      opnd_b   = VEC[i].b;
      @(negedge clk);
      chk($sformatf("R%0d vec %0d result", VEC[i].req, i), result, VEC[i].exp_res);
      chk($sformatf("R%0d vec %0d invalid", VEC[i].req, i),
          {63'd0, invalid_flag}, {63'd0, VEC[i].exp_inv});
      chk($sformatf("R11 vec %0d out_valid", i), {63'd0, out_valid}, 64'd1);
    end

    // R11 hold: idle cycle with new operands must not disturb outputs
    in_valid = 1'b0;
    op_sel   = 2'd0;
    prec_dbl = 1'b0;
    opnd_a   = 64'h7F800001;
    opnd_b   = 64'h3F800000;
    @(negedge clk);
    chk("R11 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11 idle result hold", result, 64'h2);
    chk("R11 idle invalid hold", {63'd0, invalid_flag}, 64'd0);

    // R10 then R11 reset clears a set flag
    in_valid = 1'b1;
    @(negedge clk);
    chk("R10 sNaN flag", {63'd0, invalid_flag}, 64'd1);
    chk("R3 quieted single", result, 64'h7FC00001);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    chk("R11 rerset result", result, 64'd0);
    chk("R11 rerset invalid", {63'd0, invalid_flag}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule